// File: doc/BRIEF.md
# Linear Sample to Floating-Point Compressor

This block turns a 13-bit two's-complement sample into a compact 9-bit floating-point code. The code has a sign bit, a 3-bit exponent and a 5-bit significand, and it stands for the value (-1)^S × F × 2^E. Small samples keep full resolution. Large samples keep only five significant bits, so the code covers the whole dynamic range of the input. This suits audio-style companding in front of storage or a narrow link.

The block is purely combinational and has no clock, reset or handshake. The datapath runs in four stages. First the sample becomes a sign and a magnitude. A priority encoder then finds the leading one of the magnitude and gives the exponent. A shifter picks five significand bits and one rounding bit. A final stage rounds to nearest, renormalizes when the rounding carry ripples out, and clamps to the largest code when the exponent would leave its field.

Top module: `lin2fp_compress`

## Requirements
- R1: `sign_o` always equals bit 12 of `sample_in`.
- R2: A negative sample is processed through its magnitude (bitwise invert plus one), so -x and x give identical `exp_o` and `sig_o` (e.g. -422 gives E=4, F=11010).
- R3: The sample -4096 (only bit 12 set) gives sign 1, exponent 111 and significand 11111.
- R4: For a nonzero magnitude whose highest set bit is at position p (0..11), the unrounded exponent is p-4 when p≥4, else 0. Equivalently, 1 leading zero counted from bit 12 gives E=7 and 8 or more give E=0.
- R5: The unrounded significand is the five magnitude bits from position E+4 down to E. When E=0 it is the low five bits (e.g. 422 gives E=4, F=11010).
- R6: The bit at position E-1 (the sixth bit after the leading zero) decides rounding: 1 adds one to F and 0 truncates. No rounding applies when E=0 (e.g. 0000001101101 gives 0/010/11011 and 0000001101110 gives 0/010/11100).
- R7: When rounding carries out of 11111, F becomes 10000 and E rises by one (253 gives E=4, F=10000).
- R8: If that carry would lift E above 7 (e.g. 4095), the output is E=111, F=11111 with the sign unchanged.
- R9: A zero sample gives S=0, E=000, F=00000.
- R10: Except under saturation, the expanded value F×2^E differs from the magnitude by at most 2^(E-1) (by zero when E=0). Every nonzero code has the top bit of F set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sample_in | input | 13 | Linear sample, two's complement |
| sign_o | output | 1 | Sign of the code |
| exp_o | output | 3 | Exponent of the code |
| sig_o | output | 5 | Significand of the code |

## Verification
The hardest behaviour to reach is a rounding carry from a full significand at the top exponent. It only happens for a narrow band of magnitudes just below 4096, and in both signs. The extreme input -4096, whose negation does not fit the positive range, is just as narrow. The bench drives every one of the 8192 codes in order, so both cases come up alongside every renormalization boundary. Directed samples then name each corner explicitly.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  localparam int IN_W  = 13;
  localparam int EXP_W = 3;
  localparam int SIG_W = 5;
  localparam int POS_W = $clog2(IN_W);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;

  typedef struct packed {
    logic             s;
    logic [EXP_W-1:0] e;
    logic [SIG_W-1:0] f;
  } fp_code_t;
endpackage

// File: rtl/fpc_magnitude.sv
module fpc_magnitude
  import fpc_pkg::*;
#(
  parameter int W = IN_W
) (
  input  logic [W-1:0] sample,
  output logic         neg,
  output logic [W-1:0] mag,
  output logic         too_big
);
  always_comb begin
    neg = sample[W-1];
    mag = neg ? (~sample + W'(1)) : sample;
    // only the most negative sample leaves the top bit set after negation
    too_big = mag[W-1];
  end

  always_comb begin
    a_r3_extreme_only: assert (!too_big || (sample == {1'b1, {(W-1){1'b0}}}))
      else $error("too_big raised for non-extreme sample");
  end
endmodule

// File: rtl/fpc_lead_enc.sv
module fpc_lead_enc
  import fpc_pkg::*;
#(
  parameter int W  = IN_W,
  parameter int EW = EXP_W,
  parameter int SW = SIG_W
) (
  input  logic [W-1:0]  mag,
  output logic [EW-1:0] exp_raw
);
  localparam int PW = $clog2(W);
  logic [PW-1:0] top_pos;

  always_comb begin
    top_pos = '0;
    for (int i = 0; i < W - 1; i++) begin
      if (mag[i]) top_pos = PW'(i);
    end
    if (int'(top_pos) >= SW - 1) exp_raw = EW'(int'(top_pos) - (SW - 1));
    else                         exp_raw = '0;
  end

  always_comb begin
    a_r4_lead_bit: assert (exp_raw == '0 || mag[int'(exp_raw) + SW - 1])
      else $error("exponent does not point at leading one");
  end
endmodule

// File: rtl/fpc_sig_sel.sv
module fpc_sig_sel
  import fpc_pkg::*;
#(
  parameter int W  = IN_W,
  parameter int EW = EXP_W,
  parameter int SW = SIG_W
) (
  input  logic [W-1:0]  mag,
  input  logic [EW-1:0] exp_raw,
  output logic [SW-1:0] sig_raw,
  output logic          rnd_bit
);
  logic [W:0] ext;

  always_comb begin
    ext     = {mag, 1'b0} >> exp_raw;
    sig_raw = ext[SW:1];
    rnd_bit = ext[0];
  end

  always_comb begin
    a_r6_no_round_e0: assert (exp_raw != '0 || !rnd_bit)
      else $error("rounding bit present at exponent zero");
  end
endmodule

// File: rtl/fpc_round.sv
module fpc_round
  import fpc_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int SW = SIG_W
) (
  input  logic [EW-1:0] exp_raw,
  input  logic [SW-1:0] sig_raw,
  input  logic          rnd_bit,
  input  logic          force_sat,
  output logic [EW-1:0] exp_out,
  output logic [SW-1:0] sig_out
);
  localparam logic [EW-1:0] EMAX = '1;
  logic [SW:0] sum;
  logic        carry;

  always_comb begin
    sum   = {1'b0, sig_raw} + (SW+1)'(rnd_bit);
    carry = sum[SW];
    if (force_sat || (carry && exp_raw == EMAX)) begin
      exp_out = EMAX;
      sig_out = '1;
    end else if (carry) begin
      exp_out = exp_raw + EW'(1);
      sig_out = {1'b1, {(SW-1){1'b0}}};
    end else begin
      exp_out = exp_raw;
      sig_out = sum[SW-1:0];
    end
  end

  always_comb begin
    a_r7_renorm: assert (!(rnd_bit && sig_raw == '1 && !force_sat && exp_raw != EMAX)
                         || (exp_out == exp_raw + EW'(1) && sig_out[SW-1] && sig_out[SW-2:0] == '0))
      else $error("carry not renormalized");
    a_r8_saturate: assert (!(rnd_bit && sig_raw == '1 && exp_raw == EMAX)
                           || (exp_out == EMAX && sig_out == '1))
      else $error("exponent overflow not clamped");
  end
endmodule

// File: rtl/lin2fp_compress.sv
module lin2fp_compress
  import fpc_pkg::*;
(
  input  logic [IN_W-1:0]  sample_in,
  output logic             sign_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [SIG_W-1:0] sig_o
);
  logic [IN_W-1:0]  mag;
  logic             neg, too_big, rnd_bit;
  logic [EXP_W-1:0] exp_raw;
  logic [SIG_W-1:0] sig_raw;
  fp_code_t         code;

  fpc_magnitude #(.W(IN_W)) u_mag (
    .sample(sample_in), .neg(neg), .mag(mag), .too_big(too_big)
  );

  fpc_lead_enc #(.W(IN_W), .EW(EXP_W), .SW(SIG_W)) u_enc (
    .mag(mag), .exp_raw(exp_raw)
  );

  fpc_sig_sel #(.W(IN_W), .EW(EXP_W), .SW(SIG_W)) u_sel (
    .mag(mag), .exp_raw(exp_raw), .sig_raw(sig_raw), .rnd_bit(rnd_bit)
  );

  fpc_round #(.EW(EXP_W), .SW(SIG_W)) u_rnd (
    .exp_raw(exp_raw), .sig_raw(sig_raw), .rnd_bit(rnd_bit),
    .force_sat(too_big), .exp_out(code.e), .sig_out(code.f)
  );

  assign code.s = neg;
  assign sign_o = code.s;
  assign exp_o  = code.e;
  assign sig_o  = code.f;

  always_comb begin
    a_r1_sign_msb: assert (sign_o == sample_in[IN_W-1])
      else $error("sign does not follow sample MSB");
    a_r9_zero_code: assert (sample_in != '0 || (exp_o == '0 && sig_o == '0 && !sign_o))
      else $error("zero sample gave nonzero code");
    a_r10_normalized: assert (exp_o == '0 || sig_o[SIG_W-1])
      else $error("nonzero exponent with unnormalized significand");
  end
endmodule

// File: tb/test_lin2fp_compress.sv
module test_lin2fp_compress;
  logic        clk = 1'b0;
  logic [12:0] sample_in = '0;
  logic        sign_o;
  logic [2:0]  exp_o;
  logic [4:0]  sig_o;
  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  lin2fp_compress i_lin2fp_compress (
    .sample_in(sample_in), .sign_o(sign_o), .exp_o(exp_o), .sig_o(sig_o)
  );

  // behavioural reference: returns {s,e,f}; also reports path taken
  function automatic void ref_model(input int v, output int s, output int e,
                                    output int f, output string tag);
    int m, r;
    s = (v < 0) ? 1 : 0;
    m = (v < 0) ? -v : v;
    tag = (v < 0) ? "R2" : "R4";
    if (m >= 4096) begin e = 7; f = 31; tag = "R3"; return; end
    if (m == 0) begin e = 0; f = 0; tag = "R9"; return; end
    e = 0;
    while ((m >> e) >= 32) e++;
    f = m >> e;
    r = (e > 0) ? ((m >> (e - 1)) & 1) : 0;
    if (e == 0) tag = "R5";
    if (r == 1) tag = "R6";
    f += r;
    if (f == 32) begin f = 16; e++; tag = "R7"; end
    if (e > 7) begin e = 7; f = 31; tag = "R8"; end
  endfunction

  task automatic apply(input int v, input string why);
    int s, e, f, m, ev;
    string tag;
    @(posedge clk);
    #1 sample_in = 13'(v);
    @(negedge clk);
    ref_model(v, s, e, f, tag);
    if (why != "") tag = why;
    n_checks++;
    if (int'(sign_o) != s) begin
      n_errors++;
      $display("FAIL R1 v=%0d sign actual=%0d expected=%0d", v, sign_o, s);
    end
    n_checks++;
    if (int'(exp_o) != e || int'(sig_o) != f) begin
      n_errors++;
      $display("FAIL %s v=%0d E/F actual=%0d/%0d expected=%0d/%0d",
               tag, v, exp_o, sig_o, e, f);
    end
    // R10: nearest-value bound and normalization, from the outputs alone
    m  = (v < 0) ? -v : v;
    ev = int'(sig_o) << exp_o;
    if (!(exp_o == 3'd7 && sig_o == 5'd31 && m > ev)) begin
      n_checks++;
      if ((ev - m > ((1 << exp_o) >> 1)) || (m - ev > ((1 << exp_o) >> 1))
          || (exp_o != 0 && !sig_o[4])) begin
        n_errors++;
        $display("FAIL R10 v=%0d expanded actual=%0d expected=%0d", v, ev, m);
      end
    end
  endtask

  initial begin
    // reset state: quiet input yields zero code (R9)
    apply(0, "R9");
    apply(422, "R5");
    apply(-422, "R2");
    apply(13'b0000001101100, "R6");
    apply(13'b0000001101101, "R6");
    apply(13'b0000001101110, "R6");
    apply(13'b0000001101111, "R6");
    apply(253, "R7");
    apply(4095, "R8");
    apply(-4095, "R8");
    apply(-4096, "R3");
    apply(31, "R5");
    apply(32, "R4");
    apply(-1, "R1");
    for (int v = -4096; v < 4096; v++) apply(v, "");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule